// File: doc/BRIEF.md
# Four-Lane Interleaved Sample Merger with Per-Lane Trim

This block sits behind four 20-bit converters. All four run at 40 Msps, and their sample clocks are staggered by a quarter period. Each clock cycle, every lane hands over one raw sample. The block removes that lane's offset, scales the result by that lane's gain, rounds and clamps it back to 20 bits, and presents all four corrected samples together on one 80-bit word. The word is ordered by sampling phase, so a consumer that reads it from low slot to high slot sees a single 160 Msps stream.

The correction coefficients come from a calibration pass at startup, which is done elsewhere. They are written one at a time into a shadow bank through a small write port. A single apply strobe then moves the whole shadow bank into the working bank in one cycle, so no output word is ever built from a mix of old and new coefficients.

The lanes are expected to deliver valid samples in lockstep. A word is only marked valid when all four lanes were valid for it. If the lanes disagree, a sticky flag is raised and stays set until reset.

Top module: `quad_interleave_merge`

## Requirements
- R1: After reset, `out_valid` and `misalign` are 0. Every working and shadow offset is 0 and every gain is 0x20000 (1.0), so a valid input word comes out unchanged.
- R2: Each corrected sample equals floor(((raw - offset) * gain + 65536) / 131072). Here raw and offset are signed two's-complement 20-bit values and gain is an unsigned Q1.17 value. Exact halves therefore round toward plus infinity.
- R3: A corrected value above 524287 is output as 524287, and one below -524288 is output as -524288.
- R4: `out_data[20k+19:20k]` carries lane k's corrected sample, for k = 0 to 3. Lane 0 is the earliest sampling phase.
- R5: A sample captured on clock edge E appears on the outputs after edge E+2, which is three edges counting E.
- R6: A write with `cfg_we` high stores `cfg_wdata` into the shadow bank. `cfg_addr[1:0]` selects the lane, and `cfg_addr[2]` selects the register: 0 for offset, 1 for gain. Until an apply, the output is unaffected.
- R7: `cfg_apply` copies every shadow register into the working bank on one edge. Samples captured on that same edge still use the old working bank, and samples captured later use the new one.
- R8: `out_valid` is 1 exactly when all four `lane_valid` bits were 1 on the corresponding capture edge.
- R9: `misalign` rises one edge after a cycle in which some, but not all, `lane_valid` bits are 1. It then stays 1 until reset. A cycle with every lane idle does not set it.
- R10: For a gain write, bits 19:18 of `cfg_wdata` are ignored.
- R11: When a write and an apply occur in the same cycle, the apply moves the shadow contents from before that write, and the written value lands only in the shadow bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 40 MHz sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lane_valid | input | 4 | Per-lane sample valid, bit k for lane k |
| lane_data | input | 80 | Raw signed samples, lane k in bits 20k+19:20k |
| cfg_we | input | 1 | Shadow register write enable |
| cfg_addr | input | 3 | Bit 2: 0 offset / 1 gain; bits 1:0: lane |
| cfg_wdata | input | 20 | Offset (signed) or gain (unsigned Q1.17 in bits 17:0) |
| cfg_apply | input | 1 | Copy the shadow bank into the working bank |
| out_valid | output | 1 | Merged word valid |
| out_data | output | 80 | Corrected samples in phase order, lane k in bits 20k+19:20k |
| misalign | output | 1 | Sticky lane valid disagreement flag |

## Verification
A lane pipeline register holding the wrong difference or product shows up as one mismatched 20-bit slot exactly three cycles after the sample entered. A stale or mixed coefficient bank shows up as wrong slots on the first word captured after the apply edge. A fault in the rounding or clamping stage appears only for tie values and for inputs near full scale, so the sweep steps through every gain and offset pair against small odd differences and both extremes. Any error in the valid pipeline or the sticky flag is visible at `out_valid` or `misalign` within one to three cycles of the stimulus that disturbs it.

// File: rtl/merge_pkg.sv
package merge_pkg;
    localparam int LANES_DEF     = 4;
    localparam int SAMPLE_W_DEF  = 20;
    localparam int GAIN_W_DEF    = 18;
    localparam int GAIN_FRAC_DEF = 17;
    localparam int PIPE_DEPTH    = 3;

    typedef enum logic {
        REG_OFFSET = 1'b0,
        REG_GAIN   = 1'b1
    } reg_sel_e;
endpackage

// File: rtl/coef_bank.sv
module coef_bank
    import merge_pkg::*;
#(
    parameter int LANES = LANES_DEF,
    parameter int SW    = SAMPLE_W_DEF,
    parameter int GW    = GAIN_W_DEF,
    parameter int FRAC  = GAIN_FRAC_DEF,
    parameter int AW    = $clog2(LANES) + 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_we,
    input  logic [AW-1:0]         cfg_addr,
    input  logic [SW-1:0]         cfg_wdata,
    input  logic                  cfg_apply,
    output logic [LANES*SW-1:0]   act_off,
    output logic [LANES*GW-1:0]   act_gain
);
    localparam int LW = AW - 1;
    localparam logic [GW-1:0] UNITY = GW'(1) << FRAC;

    typedef struct packed {
        logic [LANES-1:0][SW-1:0] sh_off;
        logic [LANES-1:0][GW-1:0] sh_gain;
        logic [LANES-1:0][SW-1:0] wk_off;
        logic [LANES-1:0][GW-1:0] wk_gain;
    } bank_t;

    function automatic bank_t bank_reset();
        bank_t b;
        b = '0;
        for (int i = 0; i < LANES; i++) begin
            b.sh_gain[i] = UNITY;
            b.wk_gain[i] = UNITY;
        end
        return b;
    endfunction

    bank_t         s_d, s_q;
    logic [LW-1:0] lane_idx;
    reg_sel_e      sel;

    always_comb begin
        s_d      = s_q;
        lane_idx = cfg_addr[LW-1:0];
        sel      = reg_sel_e'(cfg_addr[AW-1]);
        if (cfg_apply) begin
            s_d.wk_off  = s_q.sh_off;
            s_d.wk_gain = s_q.sh_gain;
        end
        if (cfg_we) begin
            if (sel == REG_GAIN) begin
                s_d.sh_gain[lane_idx] = cfg_wdata[GW-1:0];
            end else begin
                s_d.sh_off[lane_idx] = cfg_wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= bank_reset();
        end else begin
            s_q <= s_d;
        end
    end

    assign act_off  = s_q.wk_off;
    assign act_gain = s_q.wk_gain;

    // R6: the working bank moves only on an apply strobe
    assert_bank_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_apply |=> ($stable(act_off) && $stable(act_gain)));
endmodule

// File: rtl/lane_trim.sv
module lane_trim
    import merge_pkg::*;
#(
    parameter int SW   = SAMPLE_W_DEF,
    parameter int GW   = GAIN_W_DEF,
    parameter int FRAC = GAIN_FRAC_DEF
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [SW-1:0] raw,
    input  logic [SW-1:0] off,
    input  logic [GW-1:0] gain,
    output logic [SW-1:0] corr
);
    localparam int DW = SW + 1;
    localparam int PW = DW + GW + 1;
    localparam logic signed [PW-1:0] HALF  = {{(PW-FRAC){1'b0}}, 1'b1, {(FRAC-1){1'b0}}};
    localparam logic signed [PW-1:0] MAX_S = {{(PW-SW+1){1'b0}}, {(SW-1){1'b1}}};
    localparam logic signed [PW-1:0] MIN_S = {{(PW-SW+1){1'b1}}, {(SW-1){1'b0}}};

    typedef struct packed {
        logic signed [DW-1:0] diff;
        logic [GW-1:0]        gain;
        logic signed [PW-1:0] prod;
        logic [SW-1:0]        res;
    } trim_t;

    trim_t                s_d, s_q;
    logic signed [PW-1:0] rnd;
    logic signed [PW-1:0] shv;

    always_comb begin
        s_d      = s_q;
        // stage 1: remove offset, carry the gain alongside the sample
        s_d.diff = $signed({raw[SW-1], raw}) - $signed({off[SW-1], off});
        s_d.gain = gain;
        // stage 2: scale
        s_d.prod = PW'(s_q.diff) * PW'($signed({1'b0, s_q.gain}));
        // stage 3: round half up, clamp to the sample range
        rnd      = s_q.prod + HALF;
        shv      = rnd >>> FRAC;
        if (shv > MAX_S) begin
            s_d.res = MAX_S[SW-1:0];
        end else if (shv < MIN_S) begin
            s_d.res = MIN_S[SW-1:0];
        end else begin
            s_d.res = shv[SW-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign corr = s_q.res;

    // R2: a zero gain must yield a zero sample three cycles later
    assert_zero_gain_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (gain == '0) |-> ##3 (corr == '0));
endmodule

// File: rtl/valid_track.sv
module valid_track
    import merge_pkg::*;
#(
    parameter int LANES = LANES_DEF,
    parameter int DEPTH = PIPE_DEPTH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LANES-1:0] lane_valid,
    output logic             out_valid,
    output logic             misalign
);
    typedef struct packed {
        logic [DEPTH-1:0] pipe;
        logic             mis;
    } vtrack_t;

    vtrack_t s_d, s_q;
    logic    all_v, any_v;

    always_comb begin
        s_d   = s_q;
        all_v = &lane_valid;
        any_v = |lane_valid;
        s_d.pipe = {s_q.pipe[DEPTH-2:0], all_v};
        s_d.mis  = s_q.mis | (any_v & ~all_v);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign out_valid = s_q.pipe[DEPTH-1];
    assign misalign  = s_q.mis;

    // R8: a valid word needs every lane valid three edges earlier
    assert_word_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(&lane_valid, 3));
    // R9: disagreement raises the flag on the next edge
    assert_flag_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((|lane_valid) && !(&lane_valid)) |=> misalign);
    // R9: the flag never falls outside reset
    assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        misalign |=> misalign);
endmodule

// File: rtl/quad_interleave_merge.sv
module quad_interleave_merge
    import merge_pkg::*;
#(
    parameter int LANES = LANES_DEF,
    parameter int SW    = SAMPLE_W_DEF,
    parameter int GW    = GAIN_W_DEF,
    parameter int FRAC  = GAIN_FRAC_DEF,
    parameter int AW    = $clog2(LANES) + 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [LANES-1:0]    lane_valid,
    input  logic [LANES*SW-1:0] lane_data,
    input  logic                cfg_we,
    input  logic [AW-1:0]       cfg_addr,
    input  logic [SW-1:0]       cfg_wdata,
    input  logic                cfg_apply,
    output logic                out_valid,
    output logic [LANES*SW-1:0] out_data,
    output logic                misalign
);
    logic [LANES*SW-1:0] wk_off;
    logic [LANES*GW-1:0] wk_gain;

    coef_bank #(
        .LANES(LANES), .SW(SW), .GW(GW), .FRAC(FRAC), .AW(AW)
    ) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .cfg_addr (cfg_addr),
        .cfg_wdata(cfg_wdata),
        .cfg_apply(cfg_apply),
        .act_off  (wk_off),
        .act_gain (wk_gain)
    );

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        lane_trim #(
            .SW(SW), .GW(GW), .FRAC(FRAC)
        ) u_trim (
            .clk  (clk),
            .rst_n(rst_n),
            .raw  (lane_data[k*SW +: SW]),
            .off  (wk_off[k*SW +: SW]),
            .gain (wk_gain[k*GW +: GW]),
            .corr (out_data[k*SW +: SW])
        );
    end

    valid_track #(
        .LANES(LANES), .DEPTH(PIPE_DEPTH)
    ) u_valid (
        .clk       (clk),
        .rst_n     (rst_n),
        .lane_valid(lane_valid),
        .out_valid (out_valid),
        .misalign  (misalign)
    );
endmodule

// File: tb/quad_interleave_merge_bench.sv
module quad_interleave_merge_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  lane_valid;
    logic [79:0] lane_data;
    logic        cfg_we;
    logic [2:0]  cfg_addr;
    logic [19:0] cfg_wdata;
    logic        cfg_apply;
    logic        out_valid;
    logic [79:0] out_data;
    logic        misalign;

    always #(CLK_PERIOD/2) clk = ~clk;

    quad_interleave_merge u_quad_interleave_merge (
        .clk(clk), .rst_n(rst_n), .lane_valid(lane_valid), .lane_data(lane_data),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_apply(cfg_apply),
        .out_valid(out_valid), .out_data(out_data), .misalign(misalign)
    );

    int    n_chk = 0;
    int    n_bad = 0;
    int    cyc = 0;
    int    pat_i = 0;
    int    m_sh_off[4], m_sh_gain[4], m_wk_off[4], m_wk_gain[4];
    bit    m_mis;
    bit    exp_v[4];
    int    exp_d[4][4];
    bit    exp_sat[4][4];
    string exp_tag[4];

    function automatic int sx20(logic [19:0] v);
        return int'($signed(v));
    endfunction

    function automatic int model(int raw, int off, int g, output bit sat);
        longint d, p, r;
        d = longint'(raw) - longint'(off);
        p = d * longint'(g);
        r = (p + 64'sd65536) >>> 17;
        sat = 1'b0;
        if (r > 524287) begin r = 524287; sat = 1'b1; end
        else if (r < -524288) begin r = -524288; sat = 1'b1; end
        return int'(r);
    endfunction

    function automatic int pat(int i, int k);
        int j;
        logic [19:0] h;
        j = i % 28;
        h = 20'(i * 40503 + k * 7919 + 12345);
        if (j < 8) return j - 4 + k;
        if (j == 8) return 524287 - k;
        if (j == 9) return -524288 + k;
        if (j == 10) return 262144 + k * 1000;
        if (j == 11) return -262144 - k * 1000;
        return sx20(h);
    endfunction

    task automatic check(bit ok, string tag, string what, longint act, longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", tag, what, act, exp, cyc);
        end
    endtask

    task automatic step(bit [3:0] v, bit we, bit [2:0] addr, bit [19:0] wd, bit ap, string tag);
        int  s, ns, a, raw[4];
        bit  sat;
        @(negedge clk);
        s = cyc % 4;
        check(out_valid == exp_v[s], "R8", "out_valid", out_valid, exp_v[s]);
        if (exp_v[s]) begin
            for (int k = 0; k < 4; k++) begin
                a = sx20(out_data[20*k +: 20]);
                check(a == exp_d[s][k], exp_sat[s][k] ? "R3" : exp_tag[s],
                      $sformatf("lane %0d sample", k), a, exp_d[s][k]);
            end
        end
        check(misalign == m_mis, "R9", "misalign", misalign, m_mis);
        for (int k = 0; k < 4; k++) begin
            raw[k] = pat(pat_i, k);
            lane_data[20*k +: 20] = raw[k][19:0];
        end
        pat_i++;
        lane_valid = v;
        cfg_we = we; cfg_addr = addr; cfg_wdata = wd; cfg_apply = ap;
        ns = (cyc + 3) % 4;
        exp_v[ns] = &v;
        exp_tag[ns] = tag;
        for (int k = 0; k < 4; k++) begin
            exp_d[ns][k] = model(raw[k], m_wk_off[k], m_wk_gain[k], sat);
            exp_sat[ns][k] = sat;
        end
        if (v != 4'h0 && v != 4'hF) m_mis = 1'b1;
        if (ap) begin
            for (int k = 0; k < 4; k++) begin
                m_wk_off[k] = m_sh_off[k];
                m_wk_gain[k] = m_sh_gain[k];
            end
        end
        if (we) begin
            if (addr[2]) m_sh_gain[addr[1:0]] = int'(wd[17:0]);
            else         m_sh_off[addr[1:0]]  = sx20(wd);
        end
        cyc++;
    endtask

    task automatic stream(int n, string tag);
        for (int i = 0; i < n; i++) step(4'hF, 1'b0, 3'd0, 20'd0, 1'b0, tag);
    endtask

    task automatic wr(bit [2:0] addr, int val, bit ap, string tag);
        step(4'hF, 1'b1, addr, 20'(val), ap, tag);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_chk++; n_bad++;
        $display("FAIL R5 watchdog: actual 0 expected 1 (run did not complete)");
        summary();
    end

    initial begin
        int gains[8];
        int offs[6];
        gains = '{0, 1, 32768, 65536, 131072, 131073, 196611, 262143};
        offs  = '{0, 1, -1, 3, 300001, -524288};
        lane_valid = '0; lane_data = '0; cfg_we = 1'b0; cfg_addr = '0;
        cfg_wdata = '0; cfg_apply = 1'b0;
        for (int k = 0; k < 4; k++) begin
            m_sh_off[k] = 0; m_wk_off[k] = 0;
            m_sh_gain[k] = 131072; m_wk_gain[k] = 131072;
        end
        m_mis = 1'b0;
        for (int s = 0; s < 4; s++) begin exp_v[s] = 1'b0; exp_tag[s] = "R1"; end

        repeat (4) @(posedge clk);
        @(negedge clk);
        check(out_valid == 1'b0, "R1", "out_valid in reset", out_valid, 0);
        check(misalign == 1'b0, "R1", "misalign in reset", misalign, 0);
        rst_n = 1'b1;

        // R1: default coefficients pass samples through unchanged
        stream(10, "R1");
        // R4: distinct per-lane data shows the slot order
        stream(30, "R4");
        // R5: isolated word between idle cycles
        repeat (3) step(4'h0, 1'b0, 3'd0, 20'd0, 1'b0, "R5");
        step(4'hF, 1'b0, 3'd0, 20'd0, 1'b0, "R5");
        repeat (3) step(4'h0, 1'b0, 3'd0, 20'd0, 1'b0, "R5");

        // R6: shadow writes without apply leave output unchanged
        for (int k = 0; k < 4; k++) begin
            wr(3'(k), 1000 * (k + 1), 1'b0, "R6");
            wr(3'(4 + k), 100000 + 7 * k, 1'b0, "R6");
        end
        stream(10, "R6");
        // R7: apply switches the whole bank on one edge
        step(4'hF, 1'b0, 3'd0, 20'd0, 1'b1, "R7");
        stream(10, "R7");

        // R11: write and apply together
        wr(3'd4, 65536, 1'b1, "R11");
        stream(5, "R11");
        step(4'hF, 1'b0, 3'd0, 20'd0, 1'b1, "R11");
        stream(5, "R11");

        // R2 and R3: sweep gain and offset combinations across lanes
        for (int gi = 0; gi < 8; gi++) begin
            for (int oi = 0; oi < 6; oi++) begin
                for (int k = 0; k < 4; k++) begin
                    wr(3'(k), offs[(oi + k) % 6], 1'b0, "R2");
                    wr(3'(4 + k), gains[(gi + k) % 8], 1'b0, "R2");
                end
                step(4'hF, 1'b0, 3'd0, 20'd0, 1'b1, "R2");
                stream(28, "R2");
            end
        end

        // R10: top bits of a gain write are discarded
        wr(3'd6, 20'hC0000 | 65536, 1'b0, "R10");
        step(4'hF, 1'b0, 3'd0, 20'd0, 1'b1, "R10");
        stream(10, "R10");

        // R8: all-idle gaps mark words invalid and leave misalign low
        for (int i = 0; i < 40; i++)
            step((i % 3 == 0) ? 4'h0 : 4'hF, 1'b0, 3'd0, 20'd0, 1'b0, "R8");

        // R9: one lane drops, flag rises and stays
        step(4'b1011, 1'b0, 3'd0, 20'd0, 1'b0, "R9");
        stream(10, "R9");
        repeat (4) step(4'h0, 1'b0, 3'd0, 20'd0, 1'b0, "R9");

        summary();
    end
endmodule